// File: doc/BRIEF.md
# Chopped Sigma-Delta Integration Accumulator

This block integrates the one-bit stream of a sigma-delta modulator over a window of a programmable number of samples. Samples are taken at a rate set by a power-of-two clock divider. To remove the DC offset of the analog path, the block can chop the measurement. A secondary counter periodically reverses the polarity line that steers the analog front end. On the same sample it reverses the sign given to each modulator bit. The result is that a given back-EMF keeps moving the accumulator in the same direction, while the offset is cancelled across the segments.

A one-cycle start pulse, given while the block is idle, captures the window length, the chop selection, the divider code and the initial polarity, and then clears the accumulator. The block raises busy for the duration of the window. It drops busy and pulses done for one clock once the last sample has been added.

Top module: `chop_sd_integrator`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first clock after it, `acc` is 0 and `pol_out`, `busy` and `done` are 0.
- R2: A start pulse while idle with a nonzero `itg_len` sets `busy`, clears `acc` and drives `pol_out` to `dir_cfg`, all visible one clock later.
- R3: While busy, one sample is taken every 2^(`div_code`+3) clocks. The first sample is taken on the 2^(`div_code`+3)-th clock edge after the start edge (code 0 gives 8 clocks, code 2 gives 32, code 4 gives 128).
- R4: Each sample adds +1 to `acc` when `mod_bit` is 1 and −1 when it is 0. Both signs are swapped while the chop state is inverted. Outside samples, `acc` holds.
- R5: `acc` is two's complement and saturates at its most positive and most negative values instead of wrapping.
- R6: The chop period P is `itg_len` shifted right by `offc_sel` bits. After every P samples, `pol_out` and the sample sign both toggle, except on the final sample of the window. If P is 0, no toggling occurs.
- R7: With `offc_sel` = 0, `pol_out` keeps the value of `dir_cfg` for the whole window and every sample uses the uninverted sign.
- R8: After `itg_len` samples, `busy` falls and `done` is high for exactly one clock, in the clock after the last sample edge.
- R9: A start pulse while busy has no effect: the window, the accumulator and the polarity continue unchanged.
- R10: A start while idle with `itg_len` = 0 clears `acc`, loads `pol_out` from `dir_cfg`, leaves `busy` low and pulses `done` for one clock.
- R11: `itg_len`, `offc_sel`, `div_code` and `dir_cfg` are sampled only at start. Changing them during a window does not affect that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse for an integration window |
| dir_cfg | input | 1 | Initial polarity for the analog front end |
| mod_bit | input | 1 | Modulator output bit |
| itg_len | input | LEN_W | Window length in samples |
| offc_sel | input | 2 | Chop select: 0 off, 1..3 shift of the length |
| div_code | input | 3 | Sample divider code, factor 2^(code+3) |
| pol_out | output | 1 | Polarity control to the analog front end |
| acc | output | ACC_W | Signed saturating accumulator |
| busy | output | 1 | Window in progress |
| done | output | 1 | One-clock pulse at window end |

## Verification
The bench targets chop periods that do not divide the window evenly (length 37 with shift 3). A design that toggled on the final sample, or that reloaded one sample late, would show a wrong `pol_out` at the end or segments of drifting size. Long runs with a constant modulator bit drive `acc` into both limits; a wrapping adder would flip sign there. Start pulses and configuration changes in the middle of a window, together with a zero-length start, expose a block that restarts, re-reads its inputs or hangs busy. Small and large divider codes confirm the exact cycle of the first sample, where an off-by-one prescaler would move every accumulator step by one clock.

// File: rtl/chop_sd_integrator.sv
module chop_sd_integrator #(
  parameter int ACC_W = 16,
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    dir_cfg,
  input  logic                    mod_bit,
  input  logic [LEN_W-1:0]        itg_len,
  input  logic [1:0]              offc_sel,
  input  logic [2:0]              div_code,
  output logic                    pol_out,
  output logic signed [ACC_W-1:0] acc,
  output logic                    busy,
  output logic                    done
);
  localparam int PRE_W = 11;

  logic [LEN_W-1:0] len_cnt, flip_cnt, flip_pre;
  logic [2:0]       div_q;
  logic [PRE_W-1:0] pre_cnt;
  logic             flipped;

  wire [PRE_W-1:0] pre_lim  = (PRE_W'(1) << ({1'b0, div_q} + 4'd3)) - PRE_W'(1);
  wire             tick     = busy && (pre_cnt == pre_lim);
  wire             last     = (len_cnt == LEN_W'(1));
  wire             chop_on  = (flip_pre != '0);
  wire             flip_now = tick && !last && chop_on && (flip_cnt == LEN_W'(1));
  wire             up       = mod_bit ^ flipped;
  wire [LEN_W-1:0] preset   = (offc_sel == 2'd0) ? '0 : (itg_len >> offc_sel);

  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_nxt;

  assign sum = {acc[ACC_W-1], acc} + (up ? (ACC_W+1)'(1) : {(ACC_W+1){1'b1}});

  always_comb begin
    if (sum[ACC_W] != sum[ACC_W-1])
      acc_nxt = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      acc_nxt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      pol_out  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      flipped  <= 1'b0;
      len_cnt  <= '0;
      flip_cnt <= '0;
      flip_pre <= '0;
      div_q    <= '0;
      pre_cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc      <= '0;
          pol_out  <= dir_cfg;
          flipped  <= 1'b0;
          len_cnt  <= itg_len;
          flip_pre <= preset;
          flip_cnt <= preset;
          div_q    <= div_code;
          pre_cnt  <= '0;
          busy     <= (itg_len != '0);
          done     <= (itg_len == '0);
        end
      end else begin
        pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
        if (tick) begin
          acc     <= acc_nxt;
          len_cnt <= len_cnt - LEN_W'(1);
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          if (chop_on && !last)
            flip_cnt <= flip_now ? flip_pre : flip_cnt - LEN_W'(1);
          if (flip_now) begin
            flipped <= ~flipped;
            pol_out <= ~pol_out;
          end
        end
      end
    end
  end
endmodule

// File: rtl/chop_sd_integrator_chk.sv
module chop_sd_integrator_chk #(
  parameter int ACC_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    pol_out,
  input logic signed [ACC_W-1:0] acc,
  input logic                    busy,
  input logic                    done
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (acc == '0 && !busy && !done && !pol_out));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (acc == $past(acc) || acc == $past(acc) + 1 || acc == $past(acc) - 1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(acc) && $stable(pol_out)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && $past(busy)) |=> (acc != '0 || $past(acc) == '0 || $past(acc) == 1 || $past(acc) == -1));
endmodule

bind chop_sd_integrator chop_sd_integrator_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .pol_out(pol_out),
  .acc(acc), .busy(busy), .done(done)
);

// File: tb/chop_sd_integrator_tb_top.sv
module chop_sd_integrator_tb_top;
  localparam int ACC_W = 10;
  localparam int LEN_W = 12;
  localparam int AMAX  = (1 << (ACC_W-1)) - 1;
  localparam int AMIN  = -(1 << (ACC_W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, dir_cfg = 1'b0, mod_bit = 1'b0;
  logic [LEN_W-1:0] itg_len = '0;
  logic [1:0] offc_sel = '0;
  logic [2:0] div_code = '0;
  logic pol_out, busy, done;
  logic signed [ACC_W-1:0] acc;

  chop_sd_integrator #(.ACC_W(ACC_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dir_cfg(dir_cfg), .mod_bit(mod_bit),
    .itg_len(itg_len), .offc_sel(offc_sel), .div_code(div_code),
    .pol_out(pol_out), .acc(acc), .busy(busy), .done(done));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";
  int mod_mode = 0;

  int m_acc, m_k, m_L, m_P, m_F, m_el;
  bit m_busy, m_done, m_dir;

  function automatic int flips(int k, int L, int P);
    if (P == 0 || L == 0) return 0;
    return ((k < L) ? k : L - 1) / P;
  endfunction

  always @(posedge clk) begin
    m_done = 1'b0;
    if (rst) begin
      m_acc = 0; m_k = 0; m_L = 0; m_P = 0; m_F = 8; m_el = 0;
      m_busy = 1'b0; m_dir = 1'b0;
    end else if (m_busy) begin
      m_el++;
      if (m_el % m_F == 0) begin
        bit fl;
        fl = flips(m_k, m_L, m_P) % 2;
        m_acc += (mod_bit ^ fl) ? 1 : -1;
        if (m_acc > AMAX) m_acc = AMAX;
        if (m_acc < AMIN) m_acc = AMIN;
        m_k++;
        if (m_k == m_L) begin m_busy = 1'b0; m_done = 1'b1; end
      end
    end else if (start) begin
      m_dir = dir_cfg; m_acc = 0; m_k = 0; m_el = 0;
      m_L = int'(itg_len);
      m_P = (offc_sel == 0) ? 0 : (int'(itg_len) >> offc_sel);
      m_F = 1 << (int'(div_code) + 3);
      if (m_L == 0) m_done = 1'b1; else m_busy = 1'b1;
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ep;
    cycles++;
    ep = int'(m_dir) ^ (flips(m_k, m_L, m_P) % 2);
    check(int'(acc) == m_acc, "acc", int'(acc), m_acc);
    check(int'(pol_out) == ep, "pol_out", int'(pol_out), ep);
    check(busy == m_busy, "busy", int'(busy), int'(m_busy));
    check(done == m_done, "done", int'(done), int'(m_done));
    case (mod_mode)
      1: mod_bit <= 1'b1;
      2: mod_bit <= 1'b0;
      default: mod_bit <= 1'($urandom);
    endcase
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic window(string t, int L, int sel, int dc, bit d, int mm);
    tag = t; mod_mode = mm;
    @(negedge clk);
    start <= 1'b1; itg_len <= LEN_W'(L); offc_sel <= 2'(sel);
    div_code <= 3'(dc); dir_cfg <= d;
    @(negedge clk);
    start <= 1'b0;
    while (busy || done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check(acc == '0 && !busy && !done && !pol_out, "reset state R1", int'(acc), 0);
    rst <= 1'b0;
    @(negedge clk);

    window("R2_R4_R7", 40, 0, 0, 1'b1, 0);
    window("R6_sel1", 64, 1, 0, 1'b0, 0);
    window("R6_sel2", 64, 2, 0, 1'b1, 0);
    window("R6_sel3_uneven", 37, 3, 0, 1'b0, 1);
    window("R6_small_P0", 5, 3, 0, 1'b1, 1);
    window("R3_div2", 10, 1, 2, 1'b0, 0);
    window("R3_div4", 4, 2, 4, 1'b1, 1);

    tag = "R9_R11"; mod_mode = 0;
    @(negedge clk);
    start <= 1'b1; itg_len <= 12'd48; offc_sel <= 2'd2; div_code <= 3'd0; dir_cfg <= 1'b0;
    @(negedge clk);
    start <= 1'b0;
    repeat (60) @(negedge clk);
    itg_len <= 12'd3; offc_sel <= 2'd1; div_code <= 3'd5; dir_cfg <= 1'b1;
    start <= 1'b1;
    @(negedge clk);
    start <= 1'b0;
    check(busy == 1'b1, "busy after start while busy R9", int'(busy), 1);
    while (busy || done) @(negedge clk);
    @(negedge clk);

    window("R10_zero", 0, 1, 0, 1'b1, 0);
    check(!busy, "zero length stays idle R10", int'(busy), 0);

    window("R5_pos", 600, 0, 0, 1'b0, 1);
    check(int'(acc) == AMAX, "positive limit R5", int'(acc), AMAX);
    window("R5_neg", 600, 0, 0, 1'b1, 2);
    check(int'(acc) == AMIN, "negative limit R5", int'(acc), AMIN);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule